// File: doc/BRIEF.md
# Split-Policy Interrupt Status Word

This block holds one 32-bit interrupt status word that a host reads and writes over a plain register port. The word combines two kinds of status bit. The low 17 bits are latched flags. Each flag is set by a pulse on its own event input and stays set until the host writes a one to that bit position. The high 15 bits are live: each shows the current level of one interrupt source. The host cannot write them, and each one falls as soon as its source falls.

The block also drives a single registered interrupt request. The request is high when any status bit is set and the matching bit of an externally supplied enable mask is also set. The host bus and the sources are plain level signals. There is no streaming traffic, so no valid/ready handshake is involved and no back-pressure applies. A read is a single-cycle request. Its data appears on the following cycle.

Top module: `irq_status_reg`

## Requirements
- R1: After reset, every status bit is 0, `bus_rdata` is 0 and `irq_out` is 0.
- R2: `flag_evt[i]` high at a clock edge sets status bit i, for i from 0 to 16. The bit then stays 1 after the event input returns low. Bit 0 is the bus underrun flag, bit 1 the bus overrun flag and bit 2 the bus error flag.
- R3: A write with `bus_wr` high and `bus_addr` equal to 0x18 clears every status bit i (0..16) whose `bus_wdata[i]` is 1. Bits whose write-data bit is 0 are unchanged. A write to any other address changes nothing.
- R4: If a flag's event input is high in the same cycle that a write clears that flag, the flag ends the cycle at 1.
- R5: Status bit 17+j equals the value `live_src[j]` had at the previous clock edge, for j from 0 to 14. These bits are not latched, and writes to bits 31..17 have no effect on them.
- R6: When `bus_rd` is high and `bus_addr` is 0x18 at a clock edge, `bus_rdata` shows the status word as it stood before that edge, starting on the next cycle. In every other cycle `bus_rdata` is 0. A read changes no status bit.
- R7: `irq_out` is 1 in the cycle after an edge at which the status word ANDed with `irq_mask` was nonzero, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flag_evt | input | 17 | Set pulses for the latched flags, bits 16..0 |
| live_src | input | 15 | Live source levels shown at bits 31..17 |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data; ones clear latched flags |
| bus_rdata | output | 32 | Read data, registered |
| irq_mask | input | 32 | Enable mask applied to the status word |
| irq_out | output | 1 | Combined interrupt request, registered |

## Verification
The bench drives an event and a clearing write on the same flag in the same cycle. A design that gives the clear priority would lose that event and read the bit back as 0. It writes all ones while live sources are high, which catches a design that lets writes reach bits 31..17. It then drops a source and checks that the bit falls, which exposes any latching of live bits. It also writes to a neighbouring offset, to catch a decoder that ignores the address, and it reads and writes in the same cycle, to confirm that the read returns the value from before the write. Random traffic with mixed masks checks `irq_out` against a bench model at every cycle, which catches an off-by-one in its timing.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned FLAG_W   = 17;
  localparam int unsigned ADDR_W   = 8;
  localparam logic [ADDR_W-1:0] REG_OFS = 8'h18;
  localparam int unsigned BIT_UNDERRUN = 0;
  localparam int unsigned BIT_OVERRUN  = 1;
  localparam int unsigned BIT_BUS_ERR  = 2;
endpackage

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
  parameter int unsigned W = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flag_o
);
  for (genvar i = 0; i < W; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_o[i] <= 1'b0;
      else if (set_i[i]) flag_o[i] <= 1'b1;
      else if (clr_i[i]) flag_o[i] <= 1'b0;
    end
  end

  // a set pulse always lands, even against a clear
  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((flag_o & $past(set_i)) == $past(set_i)));
  // a flag only falls when a clear targeted it
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~flag_o & $past(flag_o) & ~$past(clr_i)) == '0));
endmodule

// File: rtl/irq_live_bank.sv
module irq_live_bank #(
  parameter int unsigned W = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src_i,
  output logic [W-1:0] lvl_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_o <= '0;
    else        lvl_o <= src_i;
  end
endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] stat_i,
  input  logic [W-1:0] mask_i,
  output logic         irq_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= |(stat_i & mask_i);
  end

  assert_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_i == '0) |=> !irq_o);
  assert_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_i == '0) |=> !irq_o);
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import irq_stat_pkg::*;
#(
  parameter int unsigned DW  = REG_W,
  parameter int unsigned FW  = FLAG_W,
  parameter int unsigned AW  = ADDR_W,
  parameter logic [AW-1:0] OFS = REG_OFS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] flag_evt,
  input  logic [DW-FW-1:0] live_src,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [DW-1:0] irq_mask,
  output logic          irq_out
);
  localparam int unsigned LW = DW - FW;

  logic          hit;
  logic [FW-1:0] clr_vec;
  logic [FW-1:0] flag_q;
  logic [LW-1:0] live_q;
  logic [DW-1:0] stat;
  logic          unused_wdata_hi;

  assign hit             = (bus_addr == OFS);
  assign clr_vec         = (bus_wr && hit) ? bus_wdata[FW-1:0] : '0;
  assign unused_wdata_hi = ^bus_wdata[DW-1:FW];
  assign stat            = {live_q, flag_q};

  irq_sticky_bank #(.W(FW)) u_sticky (
    .clk(clk), .rst_n(rst_n), .set_i(flag_evt), .clr_i(clr_vec), .flag_o(flag_q)
  );

  irq_live_bank #(.W(LW)) u_live (
    .clk(clk), .rst_n(rst_n), .src_i(live_src), .lvl_o(live_q)
  );

  irq_combine #(.W(DW)) u_comb (
    .clk(clk), .rst_n(rst_n), .stat_i(stat), .mask_i(irq_mask), .irq_o(irq_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              bus_rdata <= '0;
    else if (bus_rd && hit)  bus_rdata <= stat;
    else                     bus_rdata <= '0;
  end

  assert_live_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stat[DW-1:FW] == $past(live_src)));
  assert_rd_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && hit) |=> (bus_rdata == '0));
  assert_foreign_wr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr && flag_evt == '0) |=> (flag_q == $past(flag_q)));
endmodule

// File: tb/tb_irq_status_reg.sv
module tb_irq_status_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [16:0] flag_evt = '0;
  logic [14:0] live_src = '0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] irq_mask = '0;
  logic        irq_out;

  int checks = 0;
  int fails  = 0;

  logic [31:0] m_stat = '0;
  logic [31:0] m_rdata = '0;
  logic        m_irq = 1'b0;

  always #5 clk = ~clk;

  irq_status_reg dut (
    .clk(clk), .rst_n(rst_n), .flag_evt(flag_evt), .live_src(live_src),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_mask(irq_mask), .irq_out(irq_out)
  );

  function automatic logic [31:0] next_stat(logic [31:0] s, logic [16:0] ev,
      logic [14:0] src, logic wr, logic [7:0] a, logic [31:0] wd);
    logic [16:0] clr;
    clr = (wr && a == 8'h18) ? wd[16:0] : 17'h0;
    return {src, (s[16:0] & ~clr) | ev};
  endfunction

  task automatic chk32(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk1(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // one clock: model update from driven inputs, then compare at the falling edge
  task automatic cyc(string tag);
    @(posedge clk);
    m_rdata = (bus_rd && bus_addr == 8'h18) ? m_stat : 32'h0;
    m_irq   = |(m_stat & irq_mask);
    m_stat  = next_stat(m_stat, flag_evt, live_src, bus_wr, bus_addr, bus_wdata);
    @(negedge clk);
    chk32({tag, " rdata R6"}, bus_rdata, m_rdata);
    chk1({tag, " irq R7"}, irq_out, m_irq);
    flag_evt = '0; bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic rd_expect(string tag, logic [31:0] exp);
    bus_rd = 1'b1; bus_addr = 8'h18;
    cyc(tag);
    chk32(tag, bus_rdata, exp);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, string tag);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    cyc(tag);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk32("R1 rdata after reset", bus_rdata, 32'h0);
    chk1("R1 irq after reset", irq_out, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    irq_mask = 32'hFFFF_FFFF;
    rd_expect("R1 status after reset", 32'h0);
    chk1("R1 irq idle", irq_out, 1'b0);

    // R2: pulse error/overrun/underrun and bit 16
    flag_evt = 17'h1_0007;
    cyc("R2 set");
    rd_expect("R2 sticky after pulse", 32'h0001_0007);
    chk1("R2 irq from flags", irq_out, 1'b1);

    // R3: zero write, foreign address, then single clear
    wr(8'h18, 32'h0, "R3 zero write");
    rd_expect("R3 zero write keeps", 32'h0001_0007);
    wr(8'h1C, 32'hFFFF_FFFF, "R3 other addr");
    rd_expect("R3 other address ignored", 32'h0001_0007);
    wr(8'h18, 32'h0000_0002, "R3 clear overrun");
    rd_expect("R3 bit1 cleared", 32'h0001_0005);

    // R6: read and write in same cycle returns old value
    bus_rd = 1'b1; bus_wr = 1'b1; bus_addr = 8'h18; bus_wdata = 32'h0001_0000;
    cyc("R6 rd+wr");
    chk32("R6 read returns pre-write value", bus_rdata, 32'h0001_0005);
    rd_expect("R6 write landed after read", 32'h0000_0005);

    // R5: live bits follow, ignore writes, drop with source
    live_src = 15'h0005;
    cyc("R5 raise");
    wr(8'h18, 32'hFFFF_FFFF, "R5 write all");
    rd_expect("R5 live kept, sticky cleared", 32'h000A_0000);
    live_src = 15'h0;
    cyc("R5 drop");
    rd_expect("R5 live dropped", 32'h0);

    // R4: set and clear same cycle on bit 3
    flag_evt = 17'h0_0008; bus_wr = 1'b1; bus_addr = 8'h18; bus_wdata = 32'h8;
    cyc("R4 collide");
    rd_expect("R4 set wins", 32'h0000_0008);

    // R7: mask gating
    irq_mask = 32'h0000_0008;
    cyc("R7 enabled");
    chk1("R7 irq enabled bit", irq_out, 1'b1);
    irq_mask = 32'hFFFF_FFF7;
    cyc("R7 masked");
    chk1("R7 irq masked off", irq_out, 1'b0);

    // random traffic
    for (int n = 0; n < 400; n++) begin
      flag_evt  = 17'($urandom & $urandom & $urandom);
      live_src  = 15'($urandom & $urandom);
      bus_wr    = ($urandom % 3) == 0;
      bus_rd    = ($urandom % 2) == 0;
      bus_addr  = (($urandom % 4) == 0) ? 8'($urandom) : 8'h18;
      bus_wdata = $urandom;
      irq_mask  = ($urandom % 2) ? $urandom : ($urandom & 32'hFFFE_0000);
      cyc("rand");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule